// File: doc/BRIEF.md
# RISC Instruction Format Decoder

This block turns one 32-bit fixed-length instruction word of a load/store RISC processor into the fields and control signals that the execute stage needs. The two top bits of the word pick one of four formats: branch or upper-immediate load, subroutine call, arithmetic/logic, and memory transfer. For each word the block splits out the register indices, builds a 32-bit immediate, and raises the ALU operation, register write, memory read or write, call and branch controls.

The decoder is a single registered stage. A word presented with `valid_i` high is decoded and appears on the outputs one clock later with `valid_o` high. When `valid_i` is low, every output goes to zero on the next clock. Register 0 reads as zero in this machine, so the block never requests a write to it. A call always writes its return address to the link register, index 15. An operation code outside the supported set raises `illegal_o` and keeps every enable low.

Top module: `rdec_top`

## Requirements
- R1: `fmt_o` equals bits 31:30 of the word accepted one clock earlier (00 branch/upper-load, 01 call, 10 arithmetic/logic, 11 memory), and `valid_o` equals `valid_i` delayed by one clock.
- R2: `rs1_o` is bits 18:14 and `rs2_o` is bits 4:0; `rd_o` is bits 29:25, except for a call, where it is 15.
- R3: For formats 10 and 11, bit 13 drives `use_imm_o`, and `imm_o` is bits 12:0 sign-extended to 32 bits; for formats 00 and 01, `use_imm_o` is 1.
- R4: In format 10 the operation code is bits 24:19: 0x10 add (`alu_op_o`=0), 0x11 and (1), 0x12 or (2), 0x16 or-not (3), 0x26 shift right logical (4); `set_cc_o` is 1 for the first four and 0 for the shift; each writes `rd`.
- R5: `reg_we_o` is never 1 when the destination index is 0, even for an instruction that writes a register.
- R6: Format 01 asserts `call_o` and `reg_we_o` with `rd_o`=15, and `imm_o` is bits 29:0 shifted left by 2.
- R7: Format 00 with bits 24:22 = 100 is an upper load: `imm_o` is bits 21:0 followed by ten zero bits, `alu_op_o`=5 (pass), and `rd` is written.
- R8: Format 00 with bits 24:22 = 010 is a branch: `branch_o`=1, `imm_o` is bits 21:0 sign-extended and shifted left by 2, no register write; `cond_o` always carries bits 28:25.
- R9: In format 11 the operation code is bits 24:19: 0x00 load asserts `mem_rd_o` and writes `rd`; 0x04 store asserts `mem_wr_o` without a register write; both use `alu_op_o`=0 for the address sum.
- R10: Any other operation code in formats 00, 10 or 11 asserts `illegal_o` with `reg_we_o`, `mem_rd_o`, `mem_wr_o`, `call_o`, `branch_o` and `set_cc_o` all 0.
- R11: During reset and one clock after `valid_i` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word present |
| instr_i | input | 32 | Instruction word |
| valid_o | output | 1 | Decoded result present |
| fmt_o | output | 2 | Format class |
| rd_o | output | 5 | Destination register index |
| rs1_o | output | 5 | First source register index |
| rs2_o | output | 5 | Second source register index |
| imm_o | output | 32 | Expanded immediate |
| use_imm_o | output | 1 | Second operand comes from `imm_o` |
| alu_op_o | output | 3 | ALU operation code |
| set_cc_o | output | 1 | Update condition flags |
| reg_we_o | output | 1 | Register write enable |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| call_o | output | 1 | Subroutine call |
| branch_o | output | 1 | Conditional branch |
| cond_o | output | 4 | Branch condition field |
| illegal_o | output | 1 | Unsupported operation code |

## Verification
The assertions assume only that `valid_i` and `instr_i` are stable around the rising clock edge and that `valid_i` stays low while reset is held; any 32-bit word is otherwise allowed, since illegal codes are part of the defined behaviour. The stimulus drives inputs on the falling edge, keeps `valid_i` low during reset, and mixes directed words for each format, destination index 0 cases and unsupported codes with random words whose operation codes are drawn both from the legal set and from the full field, with `valid_i` toggled between them.

// File: rtl/rdec_pkg.sv
package rdec_pkg;
  localparam int ILEN     = 32;
  localparam int RIDX_W   = 5;
  localparam int OP3_W    = 6;
  localparam int OP2_W    = 3;
  localparam int COND_W   = 4;
  localparam int IMM13_W  = 13;
  localparam int IMM22_W  = 22;
  localparam int DISP30_W = 30;
  localparam int HI_PAD   = ILEN - IMM22_W;
  localparam int LINK_IDX = 15;

  typedef enum logic [1:0] {
    FMT_BRU  = 2'b00,
    FMT_CALL = 2'b01,
    FMT_ALU  = 2'b10,
    FMT_MEM  = 2'b11
  } fmt_e;

  typedef enum logic [2:0] {
    ALU_ADD  = 3'd0,
    ALU_AND  = 3'd1,
    ALU_OR   = 3'd2,
    ALU_ORN  = 3'd3,
    ALU_SRL  = 3'd4,
    ALU_PASS = 3'd5
  } alu_e;

  localparam logic [OP2_W-1:0] OP2_UPPER  = 3'b100;
  localparam logic [OP2_W-1:0] OP2_BRANCH = 3'b010;

  localparam logic [OP3_W-1:0] OP3_ADD   = 6'h10;
  localparam logic [OP3_W-1:0] OP3_AND   = 6'h11;
  localparam logic [OP3_W-1:0] OP3_OR    = 6'h12;
  localparam logic [OP3_W-1:0] OP3_ORN   = 6'h16;
  localparam logic [OP3_W-1:0] OP3_SRL   = 6'h26;
  localparam logic [OP3_W-1:0] OP3_LOAD  = 6'h00;
  localparam logic [OP3_W-1:0] OP3_STORE = 6'h04;

  typedef struct packed {
    fmt_e              fmt;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] rs1;
    logic [RIDX_W-1:0] rs2;
    logic [ILEN-1:0]   imm;
    logic              use_imm;
    alu_e              alu_op;
    logic              set_cc;
    logic              reg_we;
    logic              mem_rd;
    logic              mem_wr;
    logic              call;
    logic              branch;
    logic [COND_W-1:0] cond;
    logic              illegal;
  } dec_t;
endpackage

// File: rtl/rdec_fields.sv
module rdec_fields
  import rdec_pkg::*;
(
  input  logic [ILEN-1:0]   instr_i,
  output fmt_e              fmt_o,
  output logic [RIDX_W-1:0] rd_o,
  output logic [RIDX_W-1:0] rs1_o,
  output logic [RIDX_W-1:0] rs2_o,
  output logic [OP2_W-1:0]  op2_o,
  output logic [OP3_W-1:0]  op3_o,
  output logic [COND_W-1:0] cond_o,
  output logic              imm_flag_o
);
  assign fmt_o      = fmt_e'(instr_i[ILEN-1 -: 2]);
  assign rd_o       = instr_i[29 -: RIDX_W];
  assign cond_o     = instr_i[28 -: COND_W];
  assign op2_o      = instr_i[24 -: OP2_W];
  assign op3_o      = instr_i[24 -: OP3_W];
  assign rs1_o      = instr_i[18 -: RIDX_W];
  assign imm_flag_o = instr_i[IMM13_W];
  assign rs2_o      = instr_i[RIDX_W-1:0];
endmodule

// File: rtl/rdec_imm.sv
module rdec_imm
  import rdec_pkg::*;
(
  input  logic [ILEN-1:0]  instr_i,
  input  fmt_e             fmt_i,
  input  logic [OP2_W-1:0] op2_i,
  input  logic             imm_flag_i,
  output logic [ILEN-1:0]  imm_o,
  output logic             use_imm_o
);
  logic [ILEN-1:0] s13, hi22, br22, dsp30;

  assign s13   = {{(ILEN-IMM13_W){instr_i[IMM13_W-1]}}, instr_i[IMM13_W-1:0]};
  assign hi22  = {instr_i[IMM22_W-1:0], {HI_PAD{1'b0}}};
  assign br22  = {{(ILEN-IMM22_W-2){instr_i[IMM22_W-1]}}, instr_i[IMM22_W-1:0], 2'b00};
  assign dsp30 = {instr_i[DISP30_W-1:0], 2'b00};

  always_comb begin
    unique case (fmt_i)
      FMT_BRU:  imm_o = (op2_i == OP2_UPPER) ? hi22 : br22;
      FMT_CALL: imm_o = dsp30;
      default:  imm_o = s13;
    endcase
  end

  // formats 00/01 always consume the immediate
  assign use_imm_o = (fmt_i == FMT_ALU || fmt_i == FMT_MEM) ? imm_flag_i : 1'b1;
endmodule

// File: rtl/rdec_ctrl.sv
module rdec_ctrl
  import rdec_pkg::*;
(
  input  fmt_e              fmt_i,
  input  logic [OP2_W-1:0]  op2_i,
  input  logic [OP3_W-1:0]  op3_i,
  input  logic [RIDX_W-1:0] rd_i,
  output logic [RIDX_W-1:0] rd_o,
  output alu_e              alu_op_o,
  output logic              set_cc_o,
  output logic              reg_we_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              call_o,
  output logic              branch_o,
  output logic              illegal_o
);
  logic wr_req;

  always_comb begin
    alu_op_o  = ALU_ADD;
    set_cc_o  = 1'b0;
    wr_req    = 1'b0;
    mem_rd_o  = 1'b0;
    mem_wr_o  = 1'b0;
    call_o    = 1'b0;
    branch_o  = 1'b0;
    illegal_o = 1'b0;
    unique case (fmt_i)
      FMT_BRU: begin
        if (op2_i == OP2_UPPER) begin
          alu_op_o = ALU_PASS;
          wr_req   = 1'b1;
        end else if (op2_i == OP2_BRANCH) begin
          branch_o = 1'b1;
        end else begin
          illegal_o = 1'b1;
        end
      end
      FMT_CALL: begin
        call_o = 1'b1;
        wr_req = 1'b1;
      end
      FMT_ALU: begin
        wr_req   = 1'b1;
        set_cc_o = 1'b1;
        unique case (op3_i)
          OP3_ADD: alu_op_o = ALU_ADD;
          OP3_AND: alu_op_o = ALU_AND;
          OP3_OR:  alu_op_o = ALU_OR;
          OP3_ORN: alu_op_o = ALU_ORN;
          OP3_SRL: begin
            alu_op_o = ALU_SRL;
            set_cc_o = 1'b0;
          end
          default: begin
            illegal_o = 1'b1;
            wr_req    = 1'b0;
            set_cc_o  = 1'b0;
          end
        endcase
      end
      default: begin
        unique case (op3_i)
          OP3_LOAD: begin
            mem_rd_o = 1'b1;
            wr_req   = 1'b1;
          end
          OP3_STORE: mem_wr_o = 1'b1;
          default:   illegal_o = 1'b1;
        endcase
      end
    endcase
  end

  assign rd_o     = (fmt_i == FMT_CALL) ? RIDX_W'(LINK_IDX) : rd_i;
  // register 0 is hardwired to zero
  assign reg_we_o = wr_req && (rd_o != '0);
endmodule

// File: rtl/rdec_top.sv
module rdec_top
  import rdec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ILEN-1:0]   instr_i,
  output logic              valid_o,
  output logic [1:0]        fmt_o,
  output logic [RIDX_W-1:0] rd_o,
  output logic [RIDX_W-1:0] rs1_o,
  output logic [RIDX_W-1:0] rs2_o,
  output logic [ILEN-1:0]   imm_o,
  output logic              use_imm_o,
  output logic [2:0]        alu_op_o,
  output logic              set_cc_o,
  output logic              reg_we_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              call_o,
  output logic              branch_o,
  output logic [COND_W-1:0] cond_o,
  output logic              illegal_o
);
  dec_t d, q;
  logic valid_q;

  fmt_e              f_fmt;
  logic [RIDX_W-1:0] f_rd;
  logic [OP2_W-1:0]  f_op2;
  logic [OP3_W-1:0]  f_op3;
  logic              f_imm_flag;

  rdec_fields u_fields (
    .instr_i    (instr_i),
    .fmt_o      (f_fmt),
    .rd_o       (f_rd),
    .rs1_o      (d.rs1),
    .rs2_o      (d.rs2),
    .op2_o      (f_op2),
    .op3_o      (f_op3),
    .cond_o     (d.cond),
    .imm_flag_o (f_imm_flag)
  );

  rdec_imm u_imm (
    .instr_i    (instr_i),
    .fmt_i      (f_fmt),
    .op2_i      (f_op2),
    .imm_flag_i (f_imm_flag),
    .imm_o      (d.imm),
    .use_imm_o  (d.use_imm)
  );

  rdec_ctrl u_ctrl (
    .fmt_i     (f_fmt),
    .op2_i     (f_op2),
    .op3_i     (f_op3),
    .rd_i      (f_rd),
    .rd_o      (d.rd),
    .alu_op_o  (d.alu_op),
    .set_cc_o  (d.set_cc),
    .reg_we_o  (d.reg_we),
    .mem_rd_o  (d.mem_rd),
    .mem_wr_o  (d.mem_wr),
    .call_o    (d.call),
    .branch_o  (d.branch),
    .illegal_o (d.illegal)
  );

  assign d.fmt = f_fmt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q       <= '0;
      valid_q <= 1'b0;
    end else begin
      q       <= valid_i ? d : '0;
      valid_q <= valid_i;
    end
  end

  assign valid_o   = valid_q;
  assign fmt_o     = q.fmt;
  assign rd_o      = q.rd;
  assign rs1_o     = q.rs1;
  assign rs2_o     = q.rs2;
  assign imm_o     = q.imm;
  assign use_imm_o = q.use_imm;
  assign alu_op_o  = q.alu_op;
  assign set_cc_o  = q.set_cc;
  assign reg_we_o  = q.reg_we;
  assign mem_rd_o  = q.mem_rd;
  assign mem_wr_o  = q.mem_wr;
  assign call_o    = q.call;
  assign branch_o  = q.branch;
  assign cond_o    = q.cond;
  assign illegal_o = q.illegal;
endmodule

// File: rtl/rdec_chk.sv
module rdec_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic        valid_o,
  input logic [1:0]  fmt_o,
  input logic [4:0]  rd_o,
  input logic [31:0] imm_o,
  input logic        set_cc_o,
  input logic        reg_we_o,
  input logic        mem_rd_o,
  input logic        mem_wr_o,
  input logic        call_o,
  input logic        branch_o,
  input logic        illegal_o
);
  logic seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen <= 1'b0;
    else         seen <= 1'b1;
  end

  p_valid_delay_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen |-> valid_o == $past(valid_i));

  p_no_zero_dest_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> rd_o != 5'd0);

  p_call_link_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_o |-> (rd_o == 5'd15 && reg_we_o && fmt_o == 2'b01));

  p_word_offset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_o || branch_o) |-> imm_o[1:0] == 2'b00);

  p_one_action_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_rd_o, mem_wr_o, call_o, branch_o, illegal_o}));

  p_illegal_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !(reg_we_o || mem_rd_o || mem_wr_o || call_o || branch_o || set_cc_o));

  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !(reg_we_o || mem_rd_o || mem_wr_o || call_o || branch_o || illegal_o));
endmodule

bind rdec_top rdec_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .valid_o   (valid_o),
  .fmt_o     (fmt_o),
  .rd_o      (rd_o),
  .imm_o     (imm_o),
  .set_cc_o  (set_cc_o),
  .reg_we_o  (reg_we_o),
  .mem_rd_o  (mem_rd_o),
  .mem_wr_o  (mem_wr_o),
  .call_o    (call_o),
  .branch_o  (branch_o),
  .illegal_o (illegal_o)
);

// File: tb/sim_rdec_top.sv
module sim_rdec_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic        valid_o;
  logic [1:0]  fmt_o;
  logic [4:0]  rd_o, rs1_o, rs2_o;
  logic [31:0] imm_o;
  logic        use_imm_o;
  logic [2:0]  alu_op_o;
  logic        set_cc_o, reg_we_o, mem_rd_o, mem_wr_o, call_o, branch_o, illegal_o;
  logic [3:0]  cond_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdec_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .instr_i(instr_i),
    .valid_o(valid_o), .fmt_o(fmt_o), .rd_o(rd_o), .rs1_o(rs1_o), .rs2_o(rs2_o),
    .imm_o(imm_o), .use_imm_o(use_imm_o), .alu_op_o(alu_op_o), .set_cc_o(set_cc_o),
    .reg_we_o(reg_we_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .call_o(call_o),
    .branch_o(branch_o), .cond_o(cond_o), .illegal_o(illegal_o)
  );

  // expected output bundle: v fmt rd rs1 rs2 imm ui alu cc we mr mw call br cond ill
  typedef struct {
    bit v; int fmt, rd, rs1, rs2; bit [31:0] imm; bit ui; int alu;
    bit cc, we, mr, mw, cl, br; int cond; bit ill;
  } exp_t;

  exp_t exp_q[$];

  function automatic exp_t model(bit v, bit [31:0] w);
    exp_t e;
    int op3, op2;
    bit wr;
    e = '{default: 0};
    if (!v) return e;
    e.v = 1;
    e.fmt = w[31:30];
    e.rd = w[29:25]; e.rs1 = w[18:14]; e.rs2 = w[4:0]; e.cond = w[28:25];
    op3 = w[24:19]; op2 = w[24:22];
    e.imm = {{19{w[12]}}, w[12:0]};
    e.ui = w[13];
    wr = 0;
    case (e.fmt)
      0: begin
        e.ui = 1;
        if (op2 == 4) begin e.imm = w[21:0] << 10; e.alu = 5; wr = 1; end
        else begin
          e.imm = {{10{w[21]}}, w[21:0]} << 2;
          if (op2 == 2) e.br = 1; else e.ill = 1;
        end
      end
      1: begin e.ui = 1; e.imm = w[29:0] * 4; e.rd = 15; e.cl = 1; wr = 1; end
      2: begin
        if (op3 == 'h10) begin e.alu = 0; e.cc = 1; wr = 1; end
        else if (op3 == 'h11) begin e.alu = 1; e.cc = 1; wr = 1; end
        else if (op3 == 'h12) begin e.alu = 2; e.cc = 1; wr = 1; end
        else if (op3 == 'h16) begin e.alu = 3; e.cc = 1; wr = 1; end
        else if (op3 == 'h26) begin e.alu = 4; wr = 1; end
        else e.ill = 1;
      end
      default: begin
        if (op3 == 0) begin e.mr = 1; wr = 1; end
        else if (op3 == 4) e.mw = 1;
        else e.ill = 1;
      end
    endcase
    e.we = wr && (e.rd != 0);
    return e;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic compare(exp_t e);
    string ir;
    ir = (e.fmt == 1) ? "R6" : (e.fmt == 0) ? (e.br ? "R8" : "R7") : "R3";
    chk(valid_o == e.v, "R1", "valid", valid_o, e.v);
    if (!e.v) begin
      chk({reg_we_o, mem_rd_o, mem_wr_o, call_o, branch_o, illegal_o, set_cc_o, fmt_o, rd_o, imm_o} == '0,
          "R11", "idle outputs", {reg_we_o, mem_rd_o, mem_wr_o, call_o, branch_o, illegal_o}, 0);
      return;
    end
    chk(fmt_o == e.fmt, "R1", "fmt", fmt_o, e.fmt);
    chk(rd_o == e.rd, "R2", "rd", rd_o, e.rd);
    chk(rs1_o == e.rs1 && rs2_o == e.rs2, "R2", "rs1/rs2", {rs1_o, rs2_o}, {e.rs1[4:0], e.rs2[4:0]});
    chk(imm_o == e.imm, ir, "imm", imm_o, e.imm);
    chk(use_imm_o == e.ui, "R3", "use_imm", use_imm_o, e.ui);
    chk(alu_op_o == e.alu, "R4", "alu_op", alu_op_o, e.alu);
    chk(set_cc_o == e.cc, "R4", "set_cc", set_cc_o, e.cc);
    chk(reg_we_o == e.we, "R5", "reg_we", reg_we_o, e.we);
    chk(mem_rd_o == e.mr && mem_wr_o == e.mw, "R9", "mem rd/wr", {mem_rd_o, mem_wr_o}, {e.mr, e.mw});
    chk(call_o == e.cl, "R6", "call", call_o, e.cl);
    chk(branch_o == e.br && cond_o == e.cond, "R8", "branch/cond", {branch_o, cond_o}, {e.br, e.cond[3:0]});
    chk(illegal_o == e.ill, "R10", "illegal", illegal_o, e.ill);
  endtask

  // one cycle: check previous result, then present the next word
  task automatic step(bit v, bit [31:0] w);
    @(negedge clk);
    compare(exp_q.pop_front());
    valid_i = v;
    instr_i = w;
    exp_q.push_back(model(v, w));
  endtask

  function automatic bit [31:0] mk3(int f, int rd, int op3, int rs1, bit i, int lo);
    return {f[1:0], rd[4:0], op3[5:0], rs1[4:0], i, lo[12:0]};
  endfunction

  initial begin
    int legal3 [7] = '{'h10, 'h11, 'h12, 'h16, 'h26, 'h00, 'h04};
    exp_q.push_back(model(0, 0));
    repeat (3) @(negedge clk);
    // R11: reset state
    chk({valid_o, reg_we_o, mem_rd_o, mem_wr_o, call_o, branch_o, illegal_o, imm_o} == '0,
        "R11", "reset outputs", valid_o, 0);
    rst_n = 1'b1;
    // R4 ALU ops, register and immediate forms
    step(1, mk3(2, 3, 'h10, 4, 0, 5));
    step(1, mk3(2, 7, 'h11, 1, 1, 'h1fff));    // R3 negative immediate
    step(1, mk3(2, 9, 'h12, 2, 1, 'h0fff));    // R3 positive max
    step(1, mk3(2, 31, 'h16, 30, 0, 29));
    step(1, mk3(2, 6, 'h26, 5, 1, 3));
    // R5 destination 0 on an ALU op and a load
    step(1, mk3(2, 0, 'h10, 4, 1, 1));
    step(1, mk3(3, 0, 'h00, 4, 1, 8));
    // R9 load and store
    step(1, mk3(3, 12, 'h00, 14, 1, 'h1ffc));
    step(1, mk3(3, 12, 'h04, 14, 0, 2));
    // R6 call
    step(1, {2'b01, 30'h3fff_ffff});
    step(1, {2'b01, 30'h0000_0010});
    // R7 upper load, incl. rd 0
    step(1, {2'b00, 5'd8, 3'b100, 22'h3a5a5a});
    step(1, {2'b00, 5'd0, 3'b100, 22'h000001});
    // R8 branch backwards and forwards
    step(1, {2'b00, 5'b01010, 3'b010, 22'h3ffffe});
    step(1, {2'b00, 5'b10001, 3'b010, 22'h000040});
    // R10 illegal codes in each decoded format
    step(1, {2'b00, 5'd4, 3'b111, 22'h1});
    step(1, mk3(2, 4, 'h3f, 1, 0, 0));
    step(1, mk3(3, 4, 'h01, 1, 0, 0));
    // R11 gap after valid word
    step(0, mk3(2, 3, 'h10, 4, 0, 5));
    step(1, {2'b01, 30'h5});
    step(0, {2'b01, 30'h5});
    // random mix
    for (int k = 0; k < 2000; k++) begin
      bit [31:0] w;
      w = $urandom;
      if (w[7:6] != 0) w[24:19] = legal3[$urandom_range(0, 6)][5:0];
      if (w[31:30] == 0 && w[8]) w[24:22] = w[9] ? 3'b100 : 3'b010;
      step($urandom_range(0, 4) != 0, w);
    end
    step(0, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule